// File: doc/BRIEF.md
# Processor Clock Run, Halt and Single-Step Controller

This block divides a fast reference clock down to the clock of a small 8-bit processor. It also gives an operator two push buttons. The run/halt button freezes the processor clock and later releases it. The step button, while the clock is frozen, lets the processor through exactly one clock cycle. The attached processor keeps its internal state only while its clock sits high, so the output may never be frozen low and may never emit a shortened phase. A halt request is therefore held until the moment the output would next fall. At that point the output simply stays high.

Both buttons are raw mechanical contacts and are active high. Each one passes through a two-flop synchronizer and a stable-level filter. Only the press transition counts, never the release. The processor clock is a plain register in the reference clock domain. A phase counter moves it forward, and no logic gates the clock itself. A status output reports when the clock is frozen and waiting for the operator. The reset input is asynchronous and active low. It is expected to be deasserted in step with the reference clock.

Top module: `cpu_clk_ctl`

## Requirements
- R1: While reset is asserted, and on the cycle after its release, the processor clock output is low and the halted flag is low. The block starts free-running, with a fresh low phase and the phase counter cleared.
- R2: While running, every low phase and every high phase of the processor clock lasts exactly DIV_RATIO/2 reference cycles, giving one processor cycle per DIV_RATIO reference cycles (default 50, giving 25 per phase).
- R3: A run/halt press while running is held pending until the end of the current high phase. The output then stays high instead of falling, and the halted flag rises. No phase is ever cut short.
- R4: While halted, the processor clock output stays at logic high, constant.
- R5: A step press while halted produces one low phase of DIV_RATIO/2 cycles and then one high phase of DIV_RATIO/2 cycles. The output then freezes high again with the halted flag set, so there is exactly one falling edge per press.
- R6: A step press while the clock is running has no effect: no phase changes length and the block keeps running.
- R7: While a step is in progress, a further step press or a run/halt press is ignored. The step finishes with exactly one falling edge, and the block ends halted.
- R8: A run/halt press while halted resumes free-running. The output falls on the next cycle, that low phase lasts DIV_RATIO/2 cycles, and the halted flag drops together with the fall.
- R9: A button level counts only after it has held steady for DEBOUNCE_CYCLES consecutive reference cycles once synchronized. Shorter pulses have no effect. Only the low-to-high (press) transition of a button acts, and a release does nothing.
- R10: The halted flag is high exactly while the output is frozen high waiting for a run or step command. It is low while running and during a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| run_btn_i | input | 1 | Raw run/halt push button, active high |
| step_btn_i | input | 1 | Raw single-step push button, active high |
| cpu_clk_o | output | 1 | Divided processor clock, registered |
| halted_o | output | 1 | High while the clock is frozen high waiting for a command |

## Verification
The divider is measured by counting falling edges over windows whose length is a whole number of processor periods. This separates a correct ratio from a phase one cycle too long or too short, and a phase monitor confirms that every low phase has exact length. The run and step buttons are pressed in each of the three operating situations: running, halted and mid-step. Comparing edge counts and the halted flag across these cases shows whether a press acted or was ignored, and whether a halt landed on the high level. Single-cycle contact bounces and a long held press are also applied. They show that the stable-level filter works and that a release has no effect. A reset applied while halted shows that reset overrides the frozen state.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_STEP = 2'd2
  } clk_mode_e;

  localparam int unsigned NUM_BTNS = 2;
  localparam int unsigned BTN_RUN  = 0;
  localparam int unsigned BTN_STEP = 1;

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int unsigned STABLE_CYCLES = 500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic press_o
);

  localparam int unsigned CW = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES);

  logic [1:0]    sync_q;
  logic          level_q, level_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          press_q, press_d;
  logic          differs, settled;

  assign differs = (sync_q[1] != level_q);
  assign settled = (cnt_q == CW'(STABLE_CYCLES - 1));

  always_comb begin
    level_d = level_q;
    cnt_d   = cnt_q;
    press_d = 1'b0;
    if (!differs) begin
      cnt_d = '0;
    end else if (settled) begin
      level_d = sync_q[1];
      cnt_d   = '0;
      press_d = sync_q[1];
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      level_q <= 1'b0;
      cnt_q   <= '0;
      press_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], raw_i};
      level_q <= level_d;
      cnt_q   <= cnt_d;
      press_q <= press_d;
    end
  end

  assign press_o = press_q;

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int unsigned PHASE_CYCLES = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic last_o
);

  localparam int unsigned TW = (PHASE_CYCLES < 2) ? 1 : $clog2(PHASE_CYCLES);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (adv_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == TW'(PHASE_CYCLES - 1));

endmodule

// File: rtl/clk_mode_fsm.sv
module clk_mode_fsm
  import cpu_clk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_press_i,
  input  logic step_press_i,
  input  logic last_i,
  output logic clr_o,
  output logic adv_o,
  output logic cpu_clk_o,
  output logic halted_o
);

  clk_mode_e mode_q, mode_d;
  logic      lvl_q, lvl_d;
  logic      stop_q, stop_d;

  always_comb begin
    mode_d = mode_q;
    lvl_d  = lvl_q;
    stop_d = stop_q;
    clr_o  = 1'b0;
    adv_o  = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        adv_o = 1'b1;
        if (run_press_i) stop_d = 1'b1;
        if (last_i) begin
          clr_o = 1'b1;
          if (lvl_q && (stop_q || run_press_i)) begin
            mode_d = MODE_HALT;
            stop_d = 1'b0;
          end else begin
            lvl_d = ~lvl_q;
          end
        end
      end
      MODE_HALT: begin
        clr_o = 1'b1;
        if (run_press_i) begin
          mode_d = MODE_RUN;
          lvl_d  = 1'b0;
        end else if (step_press_i) begin
          mode_d = MODE_STEP;
          lvl_d  = 1'b0;
        end
      end
      MODE_STEP: begin
        adv_o = 1'b1;
        if (last_i) begin
          clr_o = 1'b1;
          if (!lvl_q) begin
            lvl_d = 1'b1;
          end else begin
            mode_d = MODE_HALT;
          end
        end
      end
      default: begin
        mode_d = MODE_RUN;
        lvl_d  = 1'b0;
        stop_d = 1'b0;
        clr_o  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      lvl_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lvl_q  <= lvl_d;
      stop_q <= stop_d;
    end
  end

  assign cpu_clk_o = lvl_q;
  assign halted_o  = (mode_q == MODE_HALT);

endmodule

// File: rtl/cpu_clk_ctl.sv
module cpu_clk_ctl
  import cpu_clk_pkg::*;
#(
  parameter int unsigned DIV_RATIO       = 50,
  parameter int unsigned DEBOUNCE_CYCLES = 500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_btn_i,
  input  logic step_btn_i,
  output logic cpu_clk_o,
  output logic halted_o
);

  localparam int unsigned HALF_CYCLES = DIV_RATIO / 2;

  logic [NUM_BTNS-1:0] raw_btn;
  logic [NUM_BTNS-1:0] btn_press;
  logic                tmr_clr, tmr_adv, tmr_last;

  assign raw_btn[BTN_RUN]  = run_btn_i;
  assign raw_btn[BTN_STEP] = step_btn_i;

  for (genvar b = 0; b < NUM_BTNS; b++) begin : g_btn
    btn_conditioner #(
      .STABLE_CYCLES(DEBOUNCE_CYCLES)
    ) u_cond (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_btn[b]),
      .press_o(btn_press[b])
    );
  end

  phase_timer #(
    .PHASE_CYCLES(HALF_CYCLES)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .adv_i (tmr_adv),
    .last_o(tmr_last)
  );

  clk_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_press_i (btn_press[BTN_RUN]),
    .step_press_i(btn_press[BTN_STEP]),
    .last_i      (tmr_last),
    .clr_o       (tmr_clr),
    .adv_o       (tmr_adv),
    .cpu_clk_o   (cpu_clk_o),
    .halted_o    (halted_o)
  );

endmodule

// File: rtl/cpu_clk_ctl_chk.sv
module cpu_clk_ctl_chk #(
  parameter int unsigned HALF_CYCLES = 25
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cpu_clk_o,
  input logic halted_o
);

  logic        prev_q;
  int unsigned len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      len_q  <= 0;
    end else if (cpu_clk_o != prev_q) begin
      prev_q <= cpu_clk_o;
      len_q  <= 1;
    end else if (len_q <= HALF_CYCLES) begin
      len_q  <= len_q + 1;
    end
  end

  // R2, R5, R8: every low phase ends after exactly the half period
  assert_low_phase_exact_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_o && !prev_q) |-> (len_q == HALF_CYCLES));

  // R3: no phase is shorter than the half period
  assert_no_runt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_o != prev_q) |-> (len_q >= HALF_CYCLES));

  // R4, R10: frozen state rests high
  assert_rest_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> cpu_clk_o);

  // R3: halt entered only from a completed high phase
  assert_halt_from_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> (cpu_clk_o && $past(cpu_clk_o)));

  // R8, R5: leaving the frozen state starts a low phase
  assert_resume_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halted_o) |-> !cpu_clk_o);

endmodule

bind cpu_clk_ctl cpu_clk_ctl_chk #(
  .HALF_CYCLES(DIV_RATIO / 2)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cpu_clk_o(cpu_clk_o),
  .halted_o (halted_o)
);

// File: tb/cpu_clk_ctl_test.sv
`timescale 1ns/1ps
module cpu_clk_ctl_test;

  localparam int DIV  = 24;
  localparam int HALF = DIV / 2;
  localparam int DEB  = 3;

  typedef struct packed {
    int act;     // 0 wait only, 1 run/halt press, 2 step press
    int wait_c;
    int falls;   // -1 = not checked
    int halted;
    int lvl;     // -1 = not checked
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{0, 96, 4, 0, -1},   // R2 free run
    '{2, 72, 4, 0, -1},   // R6 step ignored while running
    '{1, 72, -1, 1, 1},   // R3 halt lands high
    '{0, 96, 0, 1, 1},    // R4 frozen high
    '{2, 48, 1, 1, 1},    // R5 one step
    '{2, 48, 1, 1, 1},    // R5 second step
    '{1, 72, -1, 0, -1},  // R8 resume
    '{0, 96, 4, 0, -1}    // R2 running again
  };

  logic clk, rst_n, run_btn, step_btn, cpu_clk, halted;
  int   tests, fails, falls, bad_low, rest_low, low_len;
  logic prev_s, low_valid, done;

  cpu_clk_ctl #(.DIV_RATIO(DIV), .DEBOUNCE_CYCLES(DEB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_btn_i(run_btn), .step_btn_i(step_btn),
    .cpu_clk_o(cpu_clk), .halted_o(halted)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      low_valid = 1'b0;
      low_len   = 0;
    end else begin
      if (prev_s && !cpu_clk) begin
        falls++;
        low_valid = 1'b1;
        low_len   = 0;
      end
      if (!cpu_clk) low_len++;
      if (!prev_s && cpu_clk && low_valid) begin
        if (low_len != HALF) bad_low++;
        low_valid = 1'b0;
      end
      if (halted && !cpu_clk) rest_low++;
    end
    prev_s = cpu_clk;
  end

  task automatic cycle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press(input int which, input int hold, input int rel);
    if (which == 1) run_btn = 1'b1; else step_btn = 1'b1;
    cycle(hold);
    run_btn  = 1'b0;
    step_btn = 1'b0;
    cycle(rel);
  endtask

  task automatic finish_tb();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_tb();
    end
  end

  initial begin
    tests = 0; fails = 0; falls = 0; bad_low = 0; rest_low = 0;
    low_len = 0; low_valid = 1'b0; prev_s = 1'b0;
    run_btn = 1'b0; step_btn = 1'b0; rst_n = 1'b0;
    cycle(4);
    check("R1 clk in reset", int'(cpu_clk), 0);
    check("R1 halted in reset", int'(halted), 0);
    rst_n = 1'b1;
    cycle(1);
    check("R1 clk after release", int'(cpu_clk), 0);
    check("R1 halted after release", int'(halted), 0);
    cycle(30);

    for (int i = 0; i < 8; i++) begin
      falls = 0;
      if (VECS[i].act == 1) press(1, 12, 12);
      else if (VECS[i].act == 2) press(2, 12, 12);
      cycle(VECS[i].wait_c);
      if (VECS[i].falls >= 0) check($sformatf("vec%0d falls R2/R5/R6", i), falls, VECS[i].falls);
      check($sformatf("vec%0d halted R3/R8/R10", i), int'(halted), VECS[i].halted);
      if (VECS[i].lvl >= 0) check($sformatf("vec%0d level R4", i), int'(cpu_clk), VECS[i].lvl);
    end

    // Stop, then R7: second step press inside a step
    press(1, 12, 12);
    cycle(60);
    check("R3 halted before R7", int'(halted), 1);
    falls = 0;
    step_btn = 1'b1; cycle(8);
    step_btn = 1'b0; cycle(5);
    step_btn = 1'b1; cycle(8);
    step_btn = 1'b0; cycle(60);
    check("R7 step during step falls", falls, 1);
    check("R7 step during step halted", int'(halted), 1);

    // R7: run press inside a step
    falls = 0;
    step_btn = 1'b1; cycle(8);
    step_btn = 1'b0; cycle(2);
    run_btn = 1'b1; cycle(8);
    run_btn = 1'b0; cycle(60);
    check("R7 run during step falls", falls, 1);
    check("R7 run during step halted", int'(halted), 1);

    // R9: single-cycle bounces do nothing
    falls = 0;
    for (int k = 0; k < 5; k++) begin
      step_btn = 1'b1; cycle(1);
      step_btn = 1'b0; cycle(2);
      run_btn = 1'b1; cycle(1);
      run_btn = 1'b0; cycle(2);
    end
    cycle(60);
    check("R9 bounce falls", falls, 0);
    check("R9 bounce halted", int'(halted), 1);

    // R9: long hold resumes once, release does nothing
    press(1, 40, 24);
    falls = 0;
    cycle(96);
    check("R9 release ignored falls", falls, 4);
    check("R9 release ignored halted", int'(halted), 0);

    // R1: reset overrides halt
    press(1, 12, 12);
    cycle(60);
    check("R3 halted before reset", int'(halted), 1);
    rst_n = 1'b0;
    cycle(2);
    check("R1 clk reset while halted", int'(cpu_clk), 0);
    check("R1 halted reset while halted", int'(halted), 0);
    rst_n = 1'b1;
    cycle(1);
    check("R1 clk after second release", int'(cpu_clk), 0);
    cycle(60);
    check("R1 running after reset", int'(halted), 0);

    check("R2 low phase lengths wrong", bad_low, 0);
    check("R10 rested low while halted", rest_low, 0);
    finish_tb();
  end

endmodule